// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup and Replacement Unit

This unit holds the tag, valid and data arrays of a small two-way set-associative cache, together with one age bit per set. A requester presents a block address. The low `SET_W` bits of that address choose a set, and the remaining upper bits are the tag. Both ways of the chosen set are compared against the tag at the same time. On a match, the unit reports a hit in the same cycle and returns the data of the matching way along with that way's number.

When neither way matches, the unit raises `miss` and shows on `victim_way` which way a fill will overwrite. The requester fetches the block from the next memory level and keeps the same address on `req_addr`, retrying once per cycle. When the block arrives it is presented on `fill_data` with `fill_valid`. The unit writes the block into the victim way at the next clock edge, and the retried lookup then hits.

An empty way is always chosen as the victim before any valid block is evicted. When both ways are valid, the age bit picks the way that was used least recently. Every hit and every fill marks the way it touched as the youngest in its set.

Top module: `c2w_cache`

## Requirements
- R1: After reset every way of every set is invalid, so any lookup misses and `victim_way` is 0.
- R2: The set index is `req_addr[SET_W-1:0]` and the tag is `req_addr[ADDR_W-1:SET_W]`. A way hits only when it is valid and its stored tag equals the tag, and at most one way hits.
- R3: On a hit, `rd_data` carries the matching way's block, and `hit_way` is 0 for way 0 and 1 for way 1. While there is no hit, both outputs are 0.
- R4: `miss` is 1 exactly when `req_valid` is 1 and no way hits. When `req_valid` is 0, both `hit` and `miss` are 0.
- R5: `fill_valid` during a miss writes `fill_data` and the request tag into `victim_way` of the indexed set at that clock edge, and sets that way valid. A lookup of the same address in the next cycle hits.
- R6: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the least recently used way. With three tags A, B, C in one set, after the accesses A, B, A a fill of C evicts B.
- R7: A hit makes the hit way the youngest, so the other way becomes the victim of that set.
- R8: A fill makes the filled way the youngest.
- R9: `fill_valid` has no effect when there is no miss (that is, on a hit or when `req_valid` is 0). Stored blocks stay unchanged.
- R10: Hits and fills in one set change neither the contents nor the age bit of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Block address of the lookup |
| hit | output | 1 | Lookup found the block |
| hit_way | output | 1 | Way that hit (0 or 1) |
| rd_data | output | DATA_W | Block data of the hit way |
| miss | output | 1 | Request present and not found |
| victim_way | output | 1 | Way a fill of this set would replace |
| fill_valid | input | 1 | Fill block from memory is present |
| fill_data | input | DATA_W | Block data to be filled |

## Verification
Several properties are checked on every cycle:
- The two ways of a set never hold the same valid tag.
- A fill accepted during a miss leaves the written way valid.
- A lookup of the same address in the cycle after that fill hits.
- A touched way is never the next victim of its set.

Other behaviours can only be shown by the bench's scenarios, because they depend on a sequence of operations rather than a single cycle:
- The eviction order when three tags compete for one set.
- Invalid ways being preferred over the least recently used way.
- Independence between sets.
- Fills being ignored on hits or on idle cycles.

// File: rtl/c2w_pkg.sv
package c2w_pkg;

   localparam int NUM_WAYS = 2;

   // An empty way is always taken before a valid block is evicted.
   function automatic logic pick_victim(input logic v0, input logic v1, input logic older);
      logic w;
      if (!v0)
         w = 1'b0;
      else if (!v1)
         w = 1'b1;
      else
         w = older;
      return w;
   endfunction

endpackage

// File: rtl/c2w_way_store.sv
module c2w_way_store #(
   parameter int SET_W  = 3,
   parameter int TAG_W  = 13,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  idx,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              match,
   output logic              line_valid,
   output logic [DATA_W-1:0] line_data
);
   localparam int SETS = 1 << SET_W;

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (wr_en)
         valid_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[idx]  <= cmp_tag;
         data_q[idx] <= wr_data;
      end
   end

   always_comb begin
      line_valid = valid_q[idx];
      line_data  = data_q[idx];
      match      = valid_q[idx] && (tag_q[idx] == cmp_tag);
   end

   // R5
   fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(idx)]);

endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
   parameter int SET_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] idx,
   input  logic             touch,
   input  logic             touch_way,
   input  logic             valid0,
   input  logic             valid1,
   output logic             victim
);
   import c2w_pkg::*;

   localparam int SETS = 1 << SET_W;

   // One bit per set naming the older way.
   logic [SETS-1:0] older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         older_q <= '0;
      else if (touch)
         older_q[idx] <= ~touch_way;
   end

   always_comb victim = pick_victim(valid0, valid1, older_q[idx]);

   // R7
   touched_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch ##1 (idx == $past(idx)) |-> (victim != $past(touch_way)));

endmodule

// File: rtl/c2w_cache.sv
module c2w_cache #(
   parameter int ADDR_W = 16,
   parameter int SET_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit,
   output logic              hit_way,
   output logic [DATA_W-1:0] rd_data,
   output logic              miss,
   output logic              victim_way,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data
);
   import c2w_pkg::*;

   localparam int TAG_W = ADDR_W - SET_W;

   initial begin : param_chk
      assert (SET_W > 0 && SET_W < ADDR_W) else $error("SET_W must lie in 1..ADDR_W-1");
      assert (DATA_W > 0) else $error("DATA_W must be positive");
   end

   logic [SET_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic [NUM_WAYS-1:0] match_vec;
   logic [NUM_WAYS-1:0] valid_vec;
   logic [NUM_WAYS-1:0] wr_vec;
   logic [DATA_W-1:0] way_data [NUM_WAYS];
   logic              any_match;
   logic              fill_take;
   logic              touch;
   logic              touch_way;
   logic              victim;

   assign idx = req_addr[SET_W-1:0];
   assign tag = req_addr[ADDR_W-1:SET_W];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign wr_vec[w] = fill_take && (victim == w[0]);
      c2w_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .idx        (idx),
         .cmp_tag    (tag),
         .wr_en      (wr_vec[w]),
         .wr_data    (fill_data),
         .match      (match_vec[w]),
         .line_valid (valid_vec[w]),
         .line_data  (way_data[w])
      );
   end

   c2w_lru #(.SET_W(SET_W)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .touch     (touch),
      .touch_way (touch_way),
      .valid0    (valid_vec[0]),
      .valid1    (valid_vec[1]),
      .victim    (victim)
   );

   always_comb begin
      any_match  = |match_vec;
      hit        = req_valid && any_match;
      miss       = req_valid && !any_match;
      hit_way    = hit && match_vec[1];
      rd_data    = hit ? way_data[match_vec[1]] : '0;
      fill_take  = miss && fill_valid;
      touch      = hit || fill_take;
      touch_way  = hit ? match_vec[1] : victim;
      victim_way = victim;
   end

   // R2
   single_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   // R5
   fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_take |=> (!(req_valid && $stable(req_addr)) || hit));

endmodule

// File: tb/c2w_cache_bench.sv
module c2w_cache_bench;
   localparam int AW = 8;
   localparam int SW = 2;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          fill_valid = 1'b0;
   logic [DW-1:0] fill_data = '0;
   logic          hit, hit_way, miss, victim_way;
   logic [DW-1:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   c2w_cache #(.ADDR_W(AW), .SET_W(SW), .DATA_W(DW)) u_c2w_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .hit(hit), .hit_way(hit_way), .rd_data(rd_data), .miss(miss),
      .victim_way(victim_way), .fill_valid(fill_valid), .fill_data(fill_data)
   );

   typedef struct packed {
      logic          fill;
      logic [AW-1:0] addr;
      logic [DW-1:0] fdata;
      logic          e_hit;
      logic          e_way;
      logic [DW-1:0] e_data;
      logic          e_vict;
   } vec_t;

   // Set 1 tags: 0x05, 0x09, 0x0D. Set 2: 0x06.
   localparam vec_t VECS [15] = '{
      '{1'b1, 8'h05, 16'hA005, 1'b0, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 8'h05, 16'h0000, 1'b1, 1'b0, 16'hA005, 1'b1},
      '{1'b1, 8'h09, 16'hB009, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{1'b0, 8'h09, 16'h0000, 1'b1, 1'b1, 16'hB009, 1'b0},
      '{1'b0, 8'h05, 16'h0000, 1'b1, 1'b0, 16'hA005, 1'b0},
      '{1'b1, 8'h0D, 16'hC00D, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{1'b0, 8'h09, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 8'h05, 16'h0000, 1'b1, 1'b0, 16'hA005, 1'b0},
      '{1'b0, 8'h0D, 16'h0000, 1'b1, 1'b1, 16'hC00D, 1'b1},
      '{1'b1, 8'h09, 16'hB119, 1'b0, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 8'h05, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      '{1'b1, 8'h06, 16'hD006, 1'b0, 1'b0, 16'h0000, 1'b0},
      '{1'b0, 8'h06, 16'h0000, 1'b1, 1'b0, 16'hD006, 1'b1},
      '{1'b0, 8'h0D, 16'h0000, 1'b1, 1'b1, 16'hC00D, 1'b1},
      '{1'b0, 8'h09, 16'h0000, 1'b1, 1'b0, 16'hB119, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive at negedge, sample 1 ns later (before the next posedge).
   task automatic look(input logic rv, input logic [AW-1:0] a, input logic fv, input logic [DW-1:0] fd);
      @(negedge clk);
      req_valid = rv;
      req_addr = a;
      fill_valid = fv;
      fill_data = fd;
      #1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      look(1'b1, 8'h05, 1'b0, '0);
      chk("R1 hit", hit, 0);
      chk("R1 victim", victim_way, 0);

      // R4: idle request gives neither hit nor miss
      look(1'b0, 8'h05, 1'b0, '0);
      chk("R4 idle hit", hit, 0);
      chk("R4 idle miss", miss, 0);

      // Table walk: R2 R3 R5 R6 R7 R8 R10
      for (int i = 0; i < 15; i++) begin
         look(1'b1, VECS[i].addr, VECS[i].fill, VECS[i].fdata);
         chk($sformatf("R2 hit v%0d", i), hit, VECS[i].e_hit);
         chk($sformatf("R4 miss v%0d", i), miss, !VECS[i].e_hit);
         chk($sformatf("R3 way v%0d", i), hit_way, VECS[i].e_way);
         chk($sformatf("R3 data v%0d", i), rd_data, VECS[i].e_data);
         chk($sformatf("R6 victim v%0d", i), victim_way, VECS[i].e_vict);
      end

      // R9: fill during a hit is ignored
      look(1'b1, 8'h09, 1'b1, 16'hFFFF);
      chk("R9 hit during fill", hit, 1);
      look(1'b1, 8'h09, 1'b0, '0);
      chk("R9 data kept after hit fill", rd_data, 16'hB119);
      // R9: fill while idle is ignored
      look(1'b0, 8'h0D, 1'b1, 16'hEEEE);
      look(1'b1, 8'h0D, 1'b0, '0);
      chk("R9 data kept after idle fill", rd_data, 16'hC00D);
      look(1'b1, 8'h06, 1'b0, '0);
      chk("R10 other set intact", rd_data, 16'hD006);

      // R1: a second reset empties the cache again
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      fill_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(1'b1, 8'h09, 1'b0, '0);
      chk("R1 miss after reset", miss, 1);
      chk("R1 victim after reset", victim_way, 0);

      done = 1'b1;
      summary();
   end
endmodule